// File: doc/BRIEF.md
# Clocked Phase-Frequency Detector with Guaranteed Minimum Pulse

This block compares a reference input against a feedback input and produces the pump-up and pump-down commands for a charge pump. A fast system clock samples both inputs and acts as the time base. Each input passes through a synchronizer and a rising-edge detector. A detected rising edge on the reference sets the pump-up latch, and one on the feedback sets the pump-down latch. When both latches are set, a clear window of programmable length runs. At the end of the window both latches drop together.

The clear window has two effects. First, every output pulse lasts at least the window length, even at zero phase error, so the charge pump never receives a pulse too narrow to act on and the loop has no dead band. Second, the window blanks the inputs. Any rising edge detected while the window is active is lost, and the next detected edge after it becomes the leading edge of a new comparison.

For test, each completed comparison also reports a signed count: the cycles the pump-up output was high minus the cycles the pump-down output was high. A one-cycle strobe marks it.

Top module: `pfd_minpulse`

## Requirements
- R1: A rising edge on `ref_i` raises `up_o` at the (SYNC_STAGES+1)-th rising clock edge that samples `ref_i` high. With the default of 2 stages, `up_o` is low after the second such edge and high after the third.
- R2: A rising edge on `fbk_i` raises `dn_o` with the same latency as R1.
- R3: Once `up_o` and `dn_o` are both high, they stay both high for exactly MIN_PULSE cycles and then fall on the same clock edge. Neither output falls at any other time.
- R4: When the rising edges on both inputs are detected in the same cycle, both outputs are high for exactly MIN_PULSE cycles.
- R5: When one input leads the other by d cycles, the output of the leading input is high for d+MIN_PULSE cycles and the other output for MIN_PULSE cycles.
- R6: A rising edge detected in any cycle where both outputs are high, including the cycle in which they are cleared, has no effect. The first edge detected after the clear starts a new comparison as the leading edge.
- R7: When the reference runs at a higher frequency than the feedback, `up_o` is high for more cycles than `dn_o` over a long run. The mirror holds when the feedback is faster.
- R8: On the clock edge where the outputs fall, `err_valid_o` goes high for exactly one cycle. `err_o` (two's complement) then holds the number of cycles `up_o` was high minus the number of cycles `dn_o` was high in that comparison.
- R9: With `rst` high at a clock edge, both outputs and `err_valid_o` are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, the time base |
| rst | input | 1 | Synchronous active-high reset |
| ref_i | input | 1 | Reference input, asynchronous |
| fbk_i | input | 1 | Feedback input, asynchronous |
| up_o | output | 1 | Pump-up command |
| dn_o | output | 1 | Pump-down command |
| err_o | output | ERR_W | Signed phase error of the last comparison, in cycles |
| err_valid_o | output | 1 | One-cycle strobe marking `err_o` |

## Verification
Single edge pairs are applied with the reference leading, with the feedback leading, and with both edges together. This separates the leading-width rule from the fixed minimum width and confirms that the sign of the error count follows the leading side. A second reference edge is placed on the clearing edge of the window and then one cycle later, which fixes the exact boundary of blanking. Two free-running inputs with different periods, in both orders, show that the average drive favours the faster input.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Next state of one pump latch: the clear wins, an active window holds,
  // otherwise a detected edge sets it.
  function automatic logic latch_next(input logic q, input logic rise,
                                      input logic hold, input logic clr);
    if (clr) return 1'b0;
    if (hold) return q;
    return q | rise;
  endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pfd_latch_core.sv
module pfd_latch_core #(
  parameter int MIN_PULSE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic r_rise,
  input  logic v_rise,
  output logic up,
  output logic dn,
  output logic clr
);
  import pfd_pkg::*;
  localparam int CNT_W = (MIN_PULSE < 2) ? 1 : $clog2(MIN_PULSE + 1);

  logic             up_q, dn_q, both;
  logic [CNT_W-1:0] cnt_q;

  assign both = up_q & dn_q;
  assign clr  = both && (cnt_q == CNT_W'(MIN_PULSE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      up_q  <= latch_next(up_q, r_rise, both, clr);
      dn_q  <= latch_next(dn_q, v_rise, both, clr);
      cnt_q <= (both && !clr) ? cnt_q + 1'b1 : '0;
    end
  end

  assign up = up_q;
  assign dn = dn_q;
endmodule

// File: rtl/pfd_err_acc.sv
module pfd_err_acc #(
  parameter int ERR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    up,
  input  logic                    dn,
  input  logic                    clr,
  output logic signed [ERR_W-1:0] err,
  output logic                    valid
);
  localparam int CW = ERR_W - 1;

  logic [CW-1:0] uc_q, dc_q;

  function automatic logic [CW-1:0] sat_inc(input logic [CW-1:0] c);
    return (&c) ? c : c + 1'b1;
  endfunction

  function automatic logic signed [ERR_W-1:0] diff(input logic [CW-1:0] a,
                                                   input logic [CW-1:0] b);
    return $signed({1'b0, a}) - $signed({1'b0, b});
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      uc_q  <= '0;
      dc_q  <= '0;
      err   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= clr;
      if (clr) begin
        // The clearing cycle has both high, so it cancels in the difference.
        err  <= diff(uc_q, dc_q);
        uc_q <= '0;
        dc_q <= '0;
      end else begin
        if (up) uc_q <= sat_inc(uc_q);
        if (dn) dc_q <= sat_inc(dc_q);
      end
    end
  end
endmodule

// File: rtl/pfd_minpulse.sv
module pfd_minpulse #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4,
  parameter int ERR_W       = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_i,
  input  logic                    fbk_i,
  output logic                    up_o,
  output logic                    dn_o,
  output logic signed [ERR_W-1:0] err_o,
  output logic                    err_valid_o
);
  logic r_rise, v_rise, clr;

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_r (
    .clk(clk), .rst(rst), .din(ref_i), .rise(r_rise));

  pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_v (
    .clk(clk), .rst(rst), .din(fbk_i), .rise(v_rise));

  pfd_latch_core #(.MIN_PULSE(MIN_PULSE)) u_core (
    .clk(clk), .rst(rst), .r_rise(r_rise), .v_rise(v_rise),
    .up(up_o), .dn(dn_o), .clr(clr));

  pfd_err_acc #(.ERR_W(ERR_W)) u_err (
    .clk(clk), .rst(rst), .up(up_o), .dn(dn_o), .clr(clr),
    .err(err_o), .valid(err_valid_o));
endmodule

// File: rtl/pfd_minpulse_chk.sv
module pfd_minpulse_chk #(
  parameter int MIN_PULSE = 4
) (
  input logic clk,
  input logic rst,
  input logic up_o,
  input logic dn_o,
  input logic err_valid_o,
  input logic r_rise,
  input logic v_rise
);
  int  run_q;
  logic both_d_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 0;
      both_d_q <= 1'b0;
    end else begin
      both_d_q <= up_o & dn_o;
      if (up_o & dn_o) run_q <= both_d_q ? run_q + 1 : 1;
    end
  end

  AST_UP_FROM_REF: assert property (@(posedge clk) disable iff (rst)
    $rose(up_o) |-> $past(r_rise)); // R1
  AST_DN_FROM_FBK: assert property (@(posedge clk) disable iff (rst)
    $rose(dn_o) |-> $past(v_rise)); // R2
  AST_FALL_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(up_o) |-> $fell(dn_o)); // R3
  AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (rst)
    (both_d_q && !(up_o && dn_o)) |-> run_q == MIN_PULSE); // R3
  AST_STROBE_AT_FALL: assert property (@(posedge clk) disable iff (rst)
    ($fell(up_o) || $fell(dn_o)) |-> err_valid_o); // R8
  AST_STROBE_ONE: assert property (@(posedge clk) disable iff (rst)
    err_valid_o |=> !err_valid_o); // R8
endmodule

bind pfd_minpulse pfd_minpulse_chk #(.MIN_PULSE(MIN_PULSE)) u_chk (
  .clk(clk), .rst(rst), .up_o(up_o), .dn_o(dn_o),
  .err_valid_o(err_valid_o), .r_rise(r_rise), .v_rise(v_rise));

// File: tb/tb_pfd_minpulse.sv
module tb_pfd_minpulse;
  localparam int MINP = 4;
  localparam int NV   = 6;
  // ref delay, fbk delay, expected up width, dn width, error
  localparam int VEC [NV][5] = '{
    '{0, 0, 4, 4, 0},
    '{0, 3, 7, 4, 3},
    '{5, 0, 4, 9, -5},
    '{0, 1, 5, 4, 1},
    '{10, 0, 4, 14, -10},
    '{2, 2, 4, 4, 0}
  };

  logic clk = 0, rst = 1, ref_i = 0, fbk_i = 0;
  logic up_o, dn_o, err_valid_o;
  logic signed [15:0] err_o;

  pfd_minpulse #(.SYNC_STAGES(2), .MIN_PULSE(MINP), .ERR_W(16)) dut (
    .clk(clk), .rst(rst), .ref_i(ref_i), .fbk_i(fbk_i),
    .up_o(up_o), .dn_o(dn_o), .err_o(err_o), .err_valid_o(err_valid_o));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int up_w = 0, dn_w = 0, last_up = 0, last_dn = 0, last_err = 0;
  int nvalid = 0, tot_up = 0, tot_dn = 0;

  always @(negedge clk) begin
    if (rst) begin
      up_w = 0; dn_w = 0;
    end else begin
      if (up_o) begin up_w++; tot_up++; end
      if (dn_o) begin dn_w++; tot_dn++; end
      if (err_valid_o) begin
        last_up = up_w; last_dn = dn_w; last_err = int'(err_o);
        nvalid++; up_w = 0; dn_w = 0;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    ref_i = 0; fbk_i = 0; rst = 1;
    repeat (4) step();
    rst = 0;
    repeat (3) step();
  endtask

  // Second ref edge k steps after fbk rise; k=4 lands on the clearing edge.
  task automatic blank_case(input int k);
    do_reset();
    ref_i = 1; step(); step();
    fbk_i = 1; step();
    ref_i = 0;
    repeat (k - 1) step();
    ref_i = 1;
    repeat (9 - k) step();
    #1;
    chk(k == 4 ? "R6 edge on clear edge dropped" : "R6 edge after clear taken",
        int'(up_o), k == 4 ? 0 : 1);
    chk("R6 dn low after window", int'(dn_o), 0);
    chk("R8 err of blanked comparison", last_err, 2);
    if (k == 4) begin
      fbk_i = 0; step(); step();
      fbk_i = 1; step(); step(); step(); #1;
      chk("R6 next fbk edge leads (dn)", int'(dn_o), 1);
      chk("R6 next fbk edge leads (up)", int'(up_o), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    #1;
    chk("R9 up in reset", int'(up_o), 0);
    chk("R9 dn in reset", int'(dn_o), 0);
    chk("R9 valid in reset", int'(err_valid_o), 0);
    do_reset();

    // Table: R4, R5, R8
    for (int i = 0; i < NV; i++) begin
      int nv0, mx;
      nv0 = nvalid;
      mx = (VEC[i][0] > VEC[i][1]) ? VEC[i][0] : VEC[i][1];
      for (int t = 0; t <= mx; t++) begin
        if (t == VEC[i][0]) ref_i = 1;
        if (t == VEC[i][1]) fbk_i = 1;
        step();
      end
      repeat (20) step();
      ref_i = 0; fbk_i = 0;
      repeat (6) step();
      #1;
      chk("R5 up width", last_up, VEC[i][2]);
      chk("R5 dn width", last_dn, VEC[i][3]);
      chk("R8 err value", last_err, VEC[i][4]);
      chk("R8 one strobe per comparison", nvalid - nv0, 1);
    end

    // Latency R1 / R2
    do_reset();
    ref_i = 1; step(); step(); #1;
    chk("R1 up low after two sampling edges", int'(up_o), 0);
    step(); #1;
    chk("R1 up high after three sampling edges", int'(up_o), 1);
    do_reset();
    fbk_i = 1; step(); step(); #1;
    chk("R2 dn low after two sampling edges", int'(dn_o), 0);
    step(); #1;
    chk("R2 dn high after three sampling edges", int'(dn_o), 1);

    // Mid-pulse reset R9
    do_reset();
    ref_i = 1; repeat (5) step(); #1;
    chk("R9 up set before reset", int'(up_o), 1);
    rst = 1; ref_i = 0; step(); #1;
    chk("R9 up cleared by reset", int'(up_o), 0);

    // Blanking boundary R6
    blank_case(4);
    blank_case(5);

    // Frequency detection R7
    do_reset();
    tot_up = 0; tot_dn = 0;
    fork
      repeat (66) begin ref_i = 1; repeat (3) step(); ref_i = 0; repeat (3) step(); end
      repeat (40) begin fbk_i = 1; repeat (5) step(); fbk_i = 0; repeat (5) step(); end
    join
    chk("R7 faster ref favours up", int'(tot_up > tot_dn), 1);
    do_reset();
    tot_up = 0; tot_dn = 0;
    fork
      repeat (40) begin ref_i = 1; repeat (5) step(); ref_i = 0; repeat (5) step(); end
      repeat (66) begin fbk_i = 1; repeat (3) step(); fbk_i = 0; repeat (3) step(); end
    join
    chk("R7 faster fbk favours dn", int'(tot_dn > tot_up), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule